// File: doc/BRIEF.md
# USB Endpoint DMA Descriptor Scheduler

This block decides which USB endpoint the single shared DMA channel serves next. Every physical endpoint has one 32-bit pointer word in a table in memory. The table sits at a base address aligned to 128 bytes. An endpoint competes for the channel when three conditions hold: its request bit is high, its DMA-enable bit is high, and its interrupt-enable bit is low. When one or more endpoints compete, the lowest-numbered one is selected. The scheduler then reads that endpoint's table word through a simple word-wide memory port.

A non-zero pointer becomes a grant to the downstream transfer engine. The grant carries the endpoint number and the descriptor address, and it is held until the engine pulses done. The engine returns the next-pointer of the finished descriptor with the done pulse. The scheduler writes that value back into the endpoint's table word, so chained descriptors are followed one per round. A null next-pointer ends the chain.

A zero pointer means the endpoint has no descriptor. In that case the endpoint is flagged and left out of arbitration until its request drops, and the scheduler arbitrates again on the next cycle.

Top module: `usb_dd_sched`

## Requirements
- R1: After reset, `gnt_vld`, `mem_req` and every bit of `nodesc` are 0.
- R2: A table read uses `mem_we`=0 and the address (`tbl_base` with bits 6:0 forced to 0) + 4 × endpoint number. The low two address bits are always 0.
- R3: Among eligible endpoints, the one with the lowest number is fetched first.
- R4: An endpoint is eligible only when `ep_req`, `ep_dma_en` and not `ep_int_en` all hold for its bit. With no eligible endpoint, no memory access and no grant occur.
- R5: A fetched word of 0x0 produces no grant and sets `nodesc` for that endpoint. The scheduler arbitrates again in the next cycle. A flagged endpoint is not fetched again until its request drops, and its flag clears one cycle after the request is low.
- R6: A non-zero fetched word raises `gnt_vld` in the cycle after the accepting `mem_ready`. `gnt_ep` and `gnt_dd` carry the endpoint and the word, and all three hold steady until `xfer_done`. With a zero-wait memory, the grant follows eligibility by 2 cycles.
- R7: The cycle after `xfer_done`, the scheduler issues a write (`mem_we`=1) of `xfer_next_dd` to the granted endpoint's table address. It then returns to idle.
- R8: A non-zero next-pointer left in the table is granted on the endpoint's next round. A 0x0 next-pointer ends the chain, and the following round flags the endpoint if its request persists.
- R9: While `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` stay unchanged. No memory access is made while a grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_req | input | 32 | Per-endpoint event/request bits |
| ep_dma_en | input | 32 | Per-endpoint DMA enable |
| ep_int_en | input | 32 | Per-endpoint interrupt (slave) enable; 1 blocks DMA |
| tbl_base | input | 32 | Pointer table base address (bits 6:0 ignored) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data (next-pointer) |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| gnt_vld | output | 1 | Grant to transfer engine active |
| gnt_ep | output | 5 | Granted endpoint number |
| gnt_dd | output | 32 | Granted descriptor address |
| xfer_done | input | 1 | Transfer engine finished the descriptor (pulse) |
| xfer_next_dd | input | 32 | Next-pointer of the finished descriptor |
| nodesc | output | 32 | Per-endpoint no-descriptor flags |

## Verification
Inputs change on falling edges, and outputs are sampled on falling edges, in the cycle where each result is due.

The table read is due one cycle after eligibility. The grant is due two cycles after eligibility when memory has no wait states. Each stall cycle adds one cycle of delay. A null entry followed by a valid one takes four cycles.

The write-back is due one cycle after the done pulse, and the table word is compared one cycle later. The no-descriptor flag is checked two cycles after a null fetch begins, and its clearing is checked one cycle after the request drops. The bench counts the cycles to each grant and compares that count with these figures, not just the eventual grant.

// File: rtl/usb_dd_pkg.sv
package usb_dd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_GRANT = 2'd2,
    ST_WBACK = 2'd3
  } sched_st_e;

endpackage

// File: rtl/usb_dd_rst_sync.sv
module usb_dd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/usb_dd_arb.sv
module usb_dd_arb #(
  parameter int NUM_EP = 32,
  localparam int IW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] elig_i,
  output logic              any_o,
  output logic [IW-1:0]     idx_o
);

  logic [NUM_EP:0]   seen;
  logic [NUM_EP-1:0] first;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_chain
    assign first[g]  = elig_i[g] & ~seen[g];
    assign seen[g+1] = seen[g] | elig_i[g];
  end

  assign any_o = seen[NUM_EP];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (first[i]) begin
        idx_o = idx_o | IW'(i);
      end
    end
  end

  // R3
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (elig_i[idx_o] &&
               ((elig_i & ((NUM_EP'(1) << idx_o) - NUM_EP'(1))) == '0)));

endmodule

// File: rtl/usb_dd_addr.sv
module usb_dd_addr #(
  parameter int NUM_EP     = 32,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 7,
  localparam int IW = $clog2(NUM_EP)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IW-1:0]     ep_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] base_al;
  logic [ADDR_W-1:0] ofs;

  assign base_al = {base_i[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign ofs     = ADDR_W'({ep_i, 2'b00});
  assign addr_o  = base_al + ofs;

endmodule

// File: rtl/usb_dd_flags.sv
module usb_dd_flags #(
  parameter int NUM_EP = 32,
  localparam int IW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] req_i,
  input  logic              set_en_i,
  input  logic [IW-1:0]     set_idx_i,
  output logic [NUM_EP-1:0] flags_o
);

  logic [NUM_EP-1:0] flags_q;
  logic [NUM_EP-1:0] flags_d;
  logic [NUM_EP-1:0] set_vec;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_set
    assign set_vec[g] = set_en_i && (set_idx_i == IW'(g));
  end

  always_comb begin
    flags_d = (flags_q & req_i) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en_i |=> flags_o[$past(set_idx_i)]);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en_i && (req_i == '0)) |=> (flags_o == '0));

endmodule

// File: rtl/usb_dd_sched.sv
module usb_dd_sched #(
  parameter int NUM_EP     = 32,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 7,
  localparam int IW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_req,
  input  logic [NUM_EP-1:0] ep_dma_en,
  input  logic [NUM_EP-1:0] ep_int_en,
  input  logic [ADDR_W-1:0] tbl_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              gnt_vld,
  output logic [IW-1:0]     gnt_ep,
  output logic [ADDR_W-1:0] gnt_dd,
  input  logic              xfer_done,
  input  logic [ADDR_W-1:0] xfer_next_dd,
  output logic [NUM_EP-1:0] nodesc
);

  import usb_dd_pkg::*;

  logic              rst_sync_n;
  sched_st_e         st_q, st_d;
  logic [IW-1:0]     ep_q;
  logic [ADDR_W-1:0] dd_q, nxt_q;
  logic [NUM_EP-1:0] elig;
  logic              arb_any;
  logic [IW-1:0]     arb_idx;
  logic              ep_ld, dd_ld, nxt_ld;
  logic              null_hit;

  usb_dd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign elig = ep_req & ep_dma_en & ~ep_int_en & ~nodesc;

  usb_dd_arb #(.NUM_EP(NUM_EP)) u_arb (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .elig_i (elig),
    .any_o  (arb_any),
    .idx_o  (arb_idx)
  );

  usb_dd_addr #(
    .NUM_EP     (NUM_EP),
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_addr (
    .base_i (tbl_base),
    .ep_i   (ep_q),
    .addr_o (mem_addr)
  );

  assign null_hit = (st_q == ST_FETCH) && mem_ready && (mem_rdata == '0);

  usb_dd_flags #(.NUM_EP(NUM_EP)) u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_i     (ep_req),
    .set_en_i  (null_hit),
    .set_idx_i (ep_q),
    .flags_o   (nodesc)
  );

  // next-state process
  always_comb begin
    st_d   = st_q;
    ep_ld  = 1'b0;
    dd_ld  = 1'b0;
    nxt_ld = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (arb_any) begin
          ep_ld = 1'b1;
          st_d  = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_ready) begin
          if (mem_rdata == '0) begin
            st_d = ST_IDLE;
          end else begin
            dd_ld = 1'b1;
            st_d  = ST_GRANT;
          end
        end
      end
      ST_GRANT: begin
        if (xfer_done) begin
          nxt_ld = 1'b1;
          st_d   = ST_WBACK;
        end
      end
      ST_WBACK: begin
        if (mem_ready) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process with explicit enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q  <= ST_IDLE;
      ep_q  <= '0;
      dd_q  <= '0;
      nxt_q <= '0;
    end else begin
      st_q <= st_d;
      if (ep_ld) begin
        ep_q <= arb_idx;
      end
      if (dd_ld) begin
        dd_q <= mem_rdata;
      end
      if (nxt_ld) begin
        nxt_q <= xfer_next_dd;
      end
    end
  end

  assign mem_req   = (st_q == ST_FETCH) || (st_q == ST_WBACK);
  assign mem_we    = (st_q == ST_WBACK);
  assign mem_wdata = nxt_q;
  assign gnt_vld   = (st_q == ST_GRANT);
  assign gnt_ep    = ep_q;
  assign gnt_dd    = dd_q;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9
  no_mem_in_gnt_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gnt_vld |-> !mem_req);

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R6
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gnt_vld && !xfer_done) |=> (gnt_vld && $stable(gnt_ep) && $stable(gnt_dd)));

  // R6
  gnt_nonnull_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gnt_vld |-> (gnt_dd != '0));

  // R7
  wback_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gnt_vld && xfer_done) |=> (mem_req && mem_we && (mem_wdata == $past(xfer_next_dd))));

endmodule

// File: tb/usb_dd_sched_tb.sv
module usb_dd_sched_tb;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  ep_req = '0, ep_dma_en = '0, ep_int_en = '0;
  logic [31:0]   tbl_base = 32'h2000_00B5;
  logic          mem_req, mem_we, mem_ready;
  logic [31:0]   mem_addr, mem_wdata, mem_rdata;
  logic          gnt_vld;
  logic [4:0]    gnt_ep;
  logic [31:0]   gnt_dd;
  logic          xfer_done = 1'b0;
  logic [31:0]   xfer_next_dd = '0;
  logic [N-1:0]  nodesc;
  logic          stall = 1'b0;
  logic [31:0]   tbl [N];

  localparam logic [31:0] BASE_AL = 32'h2000_0080;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign mem_ready = mem_req && !stall;
  assign mem_rdata = tbl[mem_addr[6:2]];

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ready) tbl[mem_addr[6:2]] <= mem_wdata;
  end

  usb_dd_sched u_dut (
    .clk, .rst_n, .ep_req, .ep_dma_en, .ep_int_en, .tbl_base,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ready, .mem_rdata,
    .gnt_vld, .gnt_ep, .gnt_dd, .xfer_done, .xfer_next_dd, .nodesc
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wait_grant(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!gnt_vld && lat < 40);
  endtask

  task automatic finish_xfer(input int ep, input logic [31:0] nxt, input bit drop);
    xfer_done = 1'b1;
    xfer_next_dd = nxt;
    if (drop) ep_req[ep] = 1'b0;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(mem_req && mem_we, "R7 write-back request", {30'd0, mem_req, mem_we}, 32'd3);
    chk(mem_addr == BASE_AL + 32'(ep * 4), "R7 write-back address", mem_addr, BASE_AL + 32'(ep * 4));
    chk(mem_wdata == nxt, "R7 write-back data", mem_wdata, nxt);
    @(negedge clk);
    chk(tbl[ep] == nxt, "R7 table updated", tbl[ep], nxt);
    chk(!gnt_vld, "R7 idle after write-back", {31'd0, gnt_vld}, 32'd0);
  endtask

  task automatic t_reset;
    chk(!gnt_vld, "R1 gnt_vld after reset", {31'd0, gnt_vld}, 32'd0);
    chk(!mem_req, "R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk(nodesc == '0, "R1 nodesc after reset", nodesc, 32'd0);
  endtask

  task automatic t_basic;
    int lat;
    tbl[5] = 32'h1000_0040;
    ep_dma_en[5] = 1'b1;
    ep_req[5] = 1'b1;
    @(negedge clk);
    chk(mem_req && !mem_we, "R2 read issued", {30'd0, mem_req, mem_we}, 32'd2);
    chk(mem_addr == BASE_AL + 32'd20, "R2 table address", mem_addr, BASE_AL + 32'd20);
    @(negedge clk);
    chk(gnt_vld, "R6 grant after 2 cycles", {31'd0, gnt_vld}, 32'd1);
    chk(gnt_ep == 5'd5 && gnt_dd == 32'h1000_0040, "R6 grant contents", gnt_dd, 32'h1000_0040);
    repeat (3) @(negedge clk);
    chk(gnt_vld && gnt_ep == 5'd5, "R6 grant held", {27'd0, gnt_ep}, 32'd5);
    finish_xfer(5, 32'h1000_0100, 1'b1);
    ep_dma_en[5] = 1'b0;
    lat = 0;
  endtask

  task automatic t_priority;
    int lat;
    tbl[3] = 32'h3000_0000; tbl[9] = 32'h3000_0010; tbl[20] = 32'h3000_0020;
    ep_dma_en = (N'(1) << 3) | (N'(1) << 9) | (N'(1) << 20);
    ep_req = ep_dma_en;
    wait_grant(lat);
    chk(lat == 2 && gnt_ep == 5'd3, "R3 lowest first", {27'd0, gnt_ep}, 32'd3);
    finish_xfer(3, 32'h0, 1'b1);
    wait_grant(lat);
    chk(gnt_ep == 5'd9 && gnt_dd == 32'h3000_0010, "R3 next lowest", {27'd0, gnt_ep}, 32'd9);
    finish_xfer(9, 32'h0, 1'b1);
    wait_grant(lat);
    chk(gnt_ep == 5'd20 && gnt_dd == 32'h3000_0020, "R3 last", {27'd0, gnt_ep}, 32'd20);
    finish_xfer(20, 32'h0, 1'b1);
    ep_dma_en = '0;
  endtask

  task automatic t_elig;
    int lat;
    int acc;
    tbl[2] = 32'h4000_0000; tbl[4] = 32'h4000_0100; tbl[7] = 32'h4000_0200;
    ep_req[2] = 1'b1;
    ep_req[4] = 1'b1; ep_dma_en[4] = 1'b1; ep_int_en[4] = 1'b1;
    ep_dma_en[7] = 1'b1;
    acc = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mem_req || gnt_vld) acc++;
    end
    chk(acc == 0, "R4 ineligible endpoints ignored", 32'(acc), 32'd0);
    ep_dma_en[2] = 1'b1;
    wait_grant(lat);
    chk(lat == 2 && gnt_ep == 5'd2, "R4 eligible once enabled", {27'd0, gnt_ep}, 32'd2);
    finish_xfer(2, 32'h0, 1'b1);
    ep_req = '0; ep_dma_en = '0; ep_int_en = '0;
  endtask

  task automatic t_null;
    int lat;
    int acc;
    tbl[1] = 32'h0; tbl[6] = 32'h5000_0000;
    ep_dma_en[1] = 1'b1; ep_dma_en[6] = 1'b1;
    ep_req[1] = 1'b1; ep_req[6] = 1'b1;
    wait_grant(lat);
    chk(lat == 4, "R5 re-arbitration latency", 32'(lat), 32'd4);
    chk(gnt_ep == 5'd6, "R5 skips null endpoint", {27'd0, gnt_ep}, 32'd6);
    chk(nodesc == (N'(1) << 1), "R5 flag set", nodesc, 32'h2);
    finish_xfer(6, 32'h0, 1'b1);
    acc = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (mem_req) acc++;
    end
    chk(acc == 0, "R5 flagged endpoint not refetched", 32'(acc), 32'd0);
    ep_req[1] = 1'b0;
    @(negedge clk);
    chk(nodesc == '0, "R5 flag clears", nodesc, 32'd0);
    ep_dma_en = '0;
  endtask

  task automatic t_chain;
    int lat;
    tbl[12] = 32'h6000_0000;
    ep_dma_en[12] = 1'b1; ep_req[12] = 1'b1;
    wait_grant(lat);
    chk(gnt_ep == 5'd12 && gnt_dd == 32'h6000_0000, "R8 first descriptor", gnt_dd, 32'h6000_0000);
    finish_xfer(12, 32'h6000_0040, 1'b0);
    wait_grant(lat);
    chk(lat == 2 && gnt_dd == 32'h6000_0040, "R8 chained descriptor", gnt_dd, 32'h6000_0040);
    finish_xfer(12, 32'h0, 1'b0);
    repeat (2) @(negedge clk);
    chk(nodesc[12] && !gnt_vld, "R8 chain end flags endpoint", nodesc, N'(1) << 12);
    ep_req[12] = 1'b0;
    @(negedge clk);
    ep_dma_en = '0;
  endtask

  task automatic t_stall;
    logic [31:0] a0;
    tbl[8] = 32'h7000_0000;
    stall = 1'b1;
    ep_dma_en[8] = 1'b1; ep_req[8] = 1'b1;
    @(negedge clk);
    a0 = mem_addr;
    chk(mem_req && a0 == BASE_AL + 32'd32, "R2 address under stall", a0, BASE_AL + 32'd32);
    repeat (2) @(negedge clk);
    chk(mem_req && !mem_we && mem_addr == a0 && !gnt_vld, "R9 request held while stalled", mem_addr, a0);
    stall = 1'b0;
    @(negedge clk);
    chk(gnt_vld && gnt_dd == 32'h7000_0000, "R6 grant after stall release", gnt_dd, 32'h7000_0000);
    finish_xfer(8, 32'h0, 1'b1);
    ep_dma_en = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) tbl[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic;
    t_priority;
    t_elig;
    t_null;
    t_chain;
    t_stall;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule